// File: doc/BRIEF.md
# CPU Interrupt Entry Sequencer

This block is the processor-side half of interrupt handling. It holds the architectural status word, the program counter, their two save registers and the vector base. When an interrupt request is present at an instruction boundary and the status word's block bit is clear, the block takes the interrupt. In one clock it copies the status word and program counter into their save registers and sets the block and bank-select bits. It moves the program counter to the fixed handler entry at vector base plus 0x600, with no delay slot, and it acknowledges the request for one cycle.

A return strobe copies both save registers back in a single cycle. Plain load ports let surrounding pipeline logic write the status word, the program counter and the vector base. When an interrupt entry falls in the same cycle, the entry wins over those writes.

Top module: `cpu_irq_entry`

## Requirements
- R1: After reset the status word is 0x100000F0 (block bit set, mask all ones), the program counter is 0xA0000000, and the vector base, saved status and saved PC are 0. Acknowledge is low.
- R2: An interrupt is taken only on a clock edge where `insn_boundary` and `irq_req` are both high and status bit 28 (block) is 0. A request without a boundary, or a boundary without a request, changes nothing and gives no acknowledge.
- R3: On entry the saved status takes the status word from before the edge, and the saved PC takes the program counter from before the edge.
- R4: On entry status bits 28 (block) and 29 (bank select) become 1.
- R5: On entry the mask field, status bits 7..4, is unchanged, and so is every other status bit except 28 and 29.
- R6: On entry the next PC output becomes the vector base held before the edge plus 0x600, in the same cycle that acknowledge is high.
- R7: Acknowledge is a registered output. It is high for exactly the one cycle that follows the entry edge.
- R8: While status bit 28 is 1, requests at boundaries are ignored: no acknowledge, and no state changes.
- R9: A return strobe with no entry in the same cycle sets the status word from the saved status and the program counter from the saved PC in one cycle. An entry in the same cycle wins over the return, and a return wins over the status and PC load ports.
- R10: The status, PC and vector-base load ports write their registers on the next edge. Entry overrides the status and PC loads in that cycle. The vector-base load always takes effect, and only later entries use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_boundary | input | 1 | High in a cycle that ends an instruction |
| irq_req | input | 1 | Accepted request from the interrupt controller |
| irq_ack | output | 1 | One-cycle acknowledge of a taken interrupt |
| ret_strobe | input | 1 | Return from handler: restore saved registers |
| sr_wr | input | 1 | Status word load enable |
| sr_wdata | input | 32 | Status word load value |
| pc_wr | input | 1 | Program counter load enable |
| pc_wdata | input | 32 | Program counter load value |
| vbr_wr | input | 1 | Vector base load enable |
| vbr_wdata | input | 32 | Vector base load value |
| next_pc | output | 32 | Program counter to fetch from next |
| sr_q | output | 32 | Current status word |
| ssr_q | output | 32 | Saved status word |
| spc_q | output | 32 | Saved program counter |
| vbr_q | output | 32 | Vector base |

## Verification
The bench uses boundary and request patterns that differ by one cycle. A design that ignores the boundary would acknowledge too early, and one that ignores the block bit would enter twice and overwrite the first saved context. It puts an entry in the same cycle as status, PC and vector-base loads and a return strobe. A wrong priority would then leave a loaded PC or restored status where the handler address belongs, or the handler would start from the newly loaded base instead of the old one. It also uses status words with distinct mask and spare bits. A design that clears the mask or sets the wrong bits on entry shows up in the status and saved-status values.

// File: rtl/cpu_irq_entry_pkg.sv
package cpu_irq_entry_pkg;

  localparam int unsigned XLEN = 32;
  typedef logic [XLEN-1:0] word_t;

  // event chosen for one clock edge
  typedef enum logic [1:0] {
    CEV_NONE   = 2'd0,
    CEV_ENTRY  = 2'd1,
    CEV_RETURN = 2'd2
  } ctx_ev_e;

  // handler address: vector base plus fixed entry offset
  function automatic word_t handler_addr(input word_t base, input word_t ofs);
    return base + ofs;
  endfunction

  // status value written on entry: block and bank bits forced high
  function automatic word_t entry_status(input word_t cur, input int unsigned blk_pos,
                                         input int unsigned bank_pos);
    word_t r;
    r = cur;
    r[blk_pos]  = 1'b1;
    r[bank_pos] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/entry_arbiter.sv
module entry_arbiter
  import cpu_irq_entry_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    insn_boundary,
  input  logic    irq_req,
  input  logic    blocked,
  input  logic    ret_strobe,
  output ctx_ev_e ev,
  output logic    ack_q
);

  logic take;

  assign take = insn_boundary & irq_req & ~blocked;

  always_comb begin
    if (take)            ev = CEV_ENTRY;
    else if (ret_strobe) ev = CEV_RETURN;
    else                 ev = CEV_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= take;
  end

  // R7: acknowledge never spans two cycles
  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

  // R2: no acknowledge without a boundary in the cycle before
  a_r2_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_boundary |=> !ack_q);

endmodule

// File: rtl/status_unit.sv
module status_unit
  import cpu_irq_entry_pkg::*;
#(
  parameter int unsigned BLK_POS   = 28,
  parameter int unsigned BANK_POS  = 29,
  parameter int unsigned MASK_LSB  = 4,
  parameter int unsigned MASK_W    = 4,
  parameter word_t       SR_RESET  = 32'h1000_00F0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  ctx_ev_e ev,
  input  logic    sr_wr,
  input  word_t   sr_wdata,
  output word_t   sr,
  output word_t   ssr
);

  localparam int unsigned MASK_MSB = MASK_LSB + MASK_W - 1;

  word_t sr_nx, ssr_nx;

  always_comb begin
    sr_nx  = sr;
    ssr_nx = ssr;
    unique case (ev)
      CEV_ENTRY: begin
        ssr_nx = sr;
        sr_nx  = entry_status(sr, BLK_POS, BANK_POS);
      end
      CEV_RETURN: sr_nx = ssr;
      default: if (sr_wr) sr_nx = sr_wdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= SR_RESET;
      ssr <= '0;
    end else begin
      sr  <= sr_nx;
      ssr <= ssr_nx;
    end
  end

  // R5: entry keeps the mask field
  a_r5_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == CEV_ENTRY) |=> sr[MASK_MSB:MASK_LSB] == $past(sr[MASK_MSB:MASK_LSB]));

  // R4: entry leaves block and bank bits set
  a_r4_blk_bank_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == CEV_ENTRY) |=> (sr[BLK_POS] && sr[BANK_POS]));

  // R3: saved status equals the pre-entry status
  a_r3_ssr_saved: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == CEV_ENTRY) |=> ssr == $past(sr));

endmodule

// File: rtl/pc_unit.sv
module pc_unit
  import cpu_irq_entry_pkg::*;
#(
  parameter word_t PC_RESET   = 32'hA000_0000,
  parameter word_t VEC_OFFSET = 32'h0000_0600
) (
  input  logic    clk,
  input  logic    rst_n,
  input  ctx_ev_e ev,
  input  logic    pc_wr,
  input  word_t   pc_wdata,
  input  logic    vbr_wr,
  input  word_t   vbr_wdata,
  output word_t   pc,
  output word_t   spc,
  output word_t   vbr
);

  word_t pc_nx, spc_nx;

  always_comb begin
    pc_nx  = pc;
    spc_nx = spc;
    unique case (ev)
      CEV_ENTRY: begin
        spc_nx = pc;
        pc_nx  = handler_addr(vbr, VEC_OFFSET);
      end
      CEV_RETURN: pc_nx = spc;
      default: if (pc_wr) pc_nx = pc_wdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= PC_RESET;
      spc <= '0;
      vbr <= '0;
    end else begin
      pc  <= pc_nx;
      spc <= spc_nx;
      if (vbr_wr) vbr <= vbr_wdata;
    end
  end

  // R6: entry jumps straight to the handler, no delay slot
  a_r6_handler_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == CEV_ENTRY) |=> pc == $past(vbr) + VEC_OFFSET);

  // R3: saved PC equals the pre-entry PC
  a_r3_spc_saved: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == CEV_ENTRY) |=> spc == $past(pc));

endmodule

// File: rtl/cpu_irq_entry.sv
module cpu_irq_entry
  import cpu_irq_entry_pkg::*;
#(
  parameter int unsigned BLK_POS    = 28,
  parameter int unsigned BANK_POS   = 29,
  parameter int unsigned MASK_LSB   = 4,
  parameter int unsigned MASK_W     = 4,
  parameter logic [31:0] SR_RESET   = 32'h1000_00F0,
  parameter logic [31:0] PC_RESET   = 32'hA000_0000,
  parameter logic [31:0] VEC_OFFSET = 32'h0000_0600
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_boundary,
  input  logic        irq_req,
  output logic        irq_ack,
  input  logic        ret_strobe,
  input  logic        sr_wr,
  input  logic [31:0] sr_wdata,
  input  logic        pc_wr,
  input  logic [31:0] pc_wdata,
  input  logic        vbr_wr,
  input  logic [31:0] vbr_wdata,
  output logic [31:0] next_pc,
  output logic [31:0] sr_q,
  output logic [31:0] ssr_q,
  output logic [31:0] spc_q,
  output logic [31:0] vbr_q
);

  ctx_ev_e ev;
  logic    blocked;
  logic    ev_entry;
  logic    ev_return;

  assign blocked   = sr_q[BLK_POS];
  assign ev_entry  = (ev == CEV_ENTRY);
  assign ev_return = (ev == CEV_RETURN);

  entry_arbiter u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_boundary (insn_boundary),
    .irq_req       (irq_req),
    .blocked       (blocked),
    .ret_strobe    (ret_strobe),
    .ev            (ev),
    .ack_q         (irq_ack)
  );

  status_unit #(
    .BLK_POS  (BLK_POS),
    .BANK_POS (BANK_POS),
    .MASK_LSB (MASK_LSB),
    .MASK_W   (MASK_W),
    .SR_RESET (SR_RESET)
  ) u_sr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .sr_wr    (sr_wr),
    .sr_wdata (sr_wdata),
    .sr       (sr_q),
    .ssr      (ssr_q)
  );

  pc_unit #(
    .PC_RESET   (PC_RESET),
    .VEC_OFFSET (VEC_OFFSET)
  ) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .pc_wr     (pc_wr),
    .pc_wdata  (pc_wdata),
    .vbr_wr    (vbr_wr),
    .vbr_wdata (vbr_wdata),
    .pc        (next_pc),
    .spc       (spc_q),
    .vbr       (vbr_q)
  );

  // R8: a set block bit suppresses acknowledge
  a_r8_blocked_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q[BLK_POS] |=> !irq_ack);

  // R9: return restores both registers in one cycle
  a_r9_return_restore: assert property (@(posedge clk) disable iff (!rst_n)
    ev_return |=> (sr_q == $past(ssr_q)) && (next_pc == $past(spc_q)));

  // R7: acknowledge follows each entry edge
  a_r7_ack_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ev_entry |=> irq_ack);

  // R10: vector base load lands regardless of entry
  a_r10_vbr_load: assert property (@(posedge clk) disable iff (!rst_n)
    vbr_wr |=> vbr_q == $past(vbr_wdata));

endmodule

// File: tb/test_cpu_irq_entry.sv
`timescale 1ns/1ps
module test_cpu_irq_entry;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_boundary = 1'b0, irq_req = 1'b0, ret_strobe = 1'b0;
  logic        sr_wr = 1'b0, pc_wr = 1'b0, vbr_wr = 1'b0;
  logic [31:0] sr_wdata = '0, pc_wdata = '0, vbr_wdata = '0;
  logic        irq_ack;
  logic [31:0] next_pc, sr_q, ssr_q, spc_q, vbr_q;

  always #2.5 clk = ~clk;

  cpu_irq_entry i_cpu_irq_entry (
    .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .irq_req(irq_req),
    .irq_ack(irq_ack), .ret_strobe(ret_strobe), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
    .pc_wr(pc_wr), .pc_wdata(pc_wdata), .vbr_wr(vbr_wr), .vbr_wdata(vbr_wdata),
    .next_pc(next_pc), .sr_q(sr_q), .ssr_q(ssr_q), .spc_q(spc_q), .vbr_q(vbr_q)
  );

  typedef struct {
    string       tag;
    logic        ack;
    logic [31:0] sr, ssr, pc, spc, vbr;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // reference state, from the requirements
  logic [31:0] m_sr = 32'h1000_00F0, m_ssr = '0, m_pc = 32'hA000_0000, m_spc = '0, m_vbr = '0;

  task automatic chk(string tag, string fld, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, fld, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected result
  task automatic step(string tag, bit bnd, bit irq, bit ret,
                      bit s_wr, logic [31:0] s_d, bit p_wr, logic [31:0] p_d,
                      bit v_wr, logic [31:0] v_d);
    exp_t e;
    bit take;
    @(negedge clk);
    insn_boundary = bnd; irq_req = irq; ret_strobe = ret;
    sr_wr = s_wr; sr_wdata = s_d; pc_wr = p_wr; pc_wdata = p_d;
    vbr_wr = v_wr; vbr_wdata = v_d;
    take = bnd && irq && (m_sr[28] == 1'b0);
    if (take) begin
      m_ssr = m_sr;
      m_spc = m_pc;
      m_sr  = m_sr | (32'h1 << 28) | (32'h1 << 29);
      m_pc  = m_vbr + 32'h600;
    end else if (ret) begin
      m_sr = m_ssr;
      m_pc = m_spc;
    end else begin
      if (s_wr) m_sr = s_d;
      if (p_wr) m_pc = p_d;
    end
    if (v_wr) m_vbr = v_d;
    e.tag = tag; e.ack = take;
    e.sr = m_sr; e.ssr = m_ssr; e.pc = m_pc; e.spc = m_spc; e.vbr = m_vbr;
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, '0, 0, '0, 0, '0);
  endtask

  // monitor: compare just after each edge
  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "ack", {31'b0, irq_ack}, {31'b0, e.ack});
      chk(e.tag, "sr",  sr_q,    e.sr);
      chk(e.tag, "ssr", ssr_q,   e.ssr);
      chk(e.tag, "pc",  next_pc, e.pc);
      chk(e.tag, "spc", spc_q,   e.spc);
      chk(e.tag, "vbr", vbr_q,   e.vbr);
    end
  end

  initial begin
    #20000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1_reset");
    // block bit set after reset: request ignored
    step("R8_blocked_reset", 1, 1, 0, 0, '0, 0, '0, 0, '0);
    // loads: clear block bit, mask A, spare bit 0
    step("R10_loads", 0, 0, 0, 1, 32'h0000_00A3, 1, 32'h0C00_1000, 1, 32'h8C00_0000);
    step("R2_req_no_boundary", 0, 1, 0, 0, '0, 0, '0, 0, '0);
    step("R2_req_no_boundary", 0, 1, 0, 0, '0, 0, '0, 0, '0);
    step("R2_boundary_no_req", 1, 0, 0, 0, '0, 0, '0, 0, '0);
    step("R3_R4_R5_R6_entry", 1, 1, 0, 0, '0, 0, '0, 0, '0);
    idle("R7_ack_drops");
    step("R8_blocked_in_handler", 1, 1, 0, 0, '0, 0, '0, 0, '0);
    step("R9_return", 0, 0, 1, 0, '0, 0, '0, 0, '0);
    // entry with competing loads: entry wins, new base only stored
    step("R10_entry_beats_loads", 1, 1, 0, 1, 32'h0000_0050, 1, 32'h1234_5678, 1, 32'h0000_1000);
    idle("R7_ack_drops2");
    // return and request together while blocked: return acts
    step("R9_return_while_blocked", 1, 1, 1, 0, '0, 0, '0, 0, '0);
    // block bit now clear: entry beats a simultaneous return, uses new base
    step("R9_entry_beats_return", 1, 1, 1, 0, '0, 0, '0, 0, '0);
    step("R9_return2", 0, 0, 1, 0, '0, 0, '0, 0, '0);
    // return beats status/pc loads
    step("R9_return_beats_load", 0, 0, 1, 1, 32'h0000_0000, 1, 32'h0000_0000, 0, '0);
    // full mask and high spare bit
    step("R5_load_mask_f", 0, 0, 0, 1, 32'h4000_00F1, 1, 32'h0000_2222, 0, '0);
    step("R5_R6_entry_mask_f", 1, 1, 0, 0, '0, 0, '0, 0, '0);
    idle("R7_idle_end");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule